// File: doc/BRIEF.md
# SPI Flash Slave Front End with Hold

This block is the serial slave side of a flash-style memory. A fast system clock oversamples four pins: the active-low select, the serial clock, the serial data input and the active-low pause input. From these pins the block rebuilds the bit stream of each frame. It accepts both idle levels of the serial clock, so SPI Mode 0 and Mode 3 work. It assembles the bits into bytes, most significant bit first. Each finished byte goes to the command logic with a one-cycle strobe and the byte's position in the frame, so the command logic never has to look at serial timing.

For the return direction, the command logic offers a byte and an enable before each byte slot. The block shifts that byte out on the serial output and drives a separate output-enable for the pad's tristate buffer. The pause input freezes a frame without ending it. Entry into and exit from a pause happen only while the serial clock is low. If the clock is high at the moment the pause pin changes, the change waits for the next low phase. Releasing the select during a pause, or at any other time, drops the partial frame and returns the block to standby.

Top module: `spi_flash_front`

## Requirements
- R1: While the select pin is high, serial clock and data activity produce no byte strobe and `sdo_oe` stays low.
- R2: Data input bits are captured on rising serial clock edges, most significant bit first. After eight captured bits, `rx_byte` holds the byte and `rx_valid` is high for exactly one system clock cycle.
- R3: `rx_index` is 0 for the first byte of a frame and rises by one for each later byte. It saturates at 2^IDX_W-1.
- R4: A frame gives the same bytes whether the serial clock idles low (Mode 0) or idles high (Mode 3) while the select pin is high.
- R5: On the first falling serial clock edge of a byte slot (no bit of that byte yet captured), `tx_data` is loaded and `tx_en` is sampled. Bit 7 appears on `sdo` first, and each later falling edge moves to the next lower bit. `sdo_oe` follows the sampled `tx_en`.
- R6: With the select low, a low pause pin puts the block on hold only while the serial clock is low. If the clock is high when the pin falls, entry waits for the next low phase, and that falling edge is still processed.
- R7: On hold, serial clock edges and data bits are ignored and `sdo_oe` is low. Exit requires the pause pin high and the clock low. If the clock is high when the pin rises, exit waits for the next low phase, and that falling edge is not processed.
- R8: A select rising edge during hold returns the block to standby and discards the partial byte. The next frame starts again at bit 0 and index 0.
- R9: A select rising edge at any point clears the bit and byte counters and drives `sdo_oe` low.
- R10: After a hold exit, `sdo_oe` and `sdo` return to the values they had before the hold. The frame then continues from the same bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_pin | input | 1 | Active-low select pin, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| sdi_pin | input | 1 | Serial data input pin, asynchronous |
| hold_n_pin | input | 1 | Active-low pause pin, asynchronous |
| tx_data | input | 8 | Response byte offered for the next byte slot |
| tx_en | input | 1 | Drive the serial output during the next byte slot |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output enable for the serial output pad |
| rx_byte | output | 8 | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |
| rx_index | output | IDX_W | Position of `rx_byte` within the frame |

## Verification
The bench builds the block with IDX_W set to 3. A ten-byte frame therefore pushes the byte index past its ceiling of 7, which makes the saturation in R3 observable. The default of two synchronizer stages is kept. The serial clock half period is four system clocks, which meets the one-quarter rate limit and still gives every edge a settled sampling point. Under these settings, one bench run reaches both clock idle levels, prompt and deferred hold entry and exit in the middle of a byte, aborts with and without hold, and response shifting.

// File: rtl/sff_pkg.sv
// Shared types and constants for the SPI flash slave front end.
// Assumes: byte-oriented serial framing; the pin vector order below is
// used by the top level when it packs pins into the synchronizer.
package sff_pkg;
    localparam int SFF_BYTE_W = 8;

    // bit positions inside the synchronized pin vector
    localparam int PIN_CS   = 0;
    localparam int PIN_SCK  = 1;
    localparam int PIN_SDI  = 2;
    localparam int PIN_HOLD = 3;
    localparam int PIN_NUM  = 4;

    // pause controller phase
    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_HELD = 1'b1
    } hold_ph_t;
endpackage

// File: rtl/sff_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes: each bit is independent; the reset value sets the idle level of
// each pin so that no false edge appears after reset.
module sff_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // first stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
    end

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            // each later stage re-registers the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) st[k] <= RST_VAL;
                else        st[k] <= st[k-1];
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/sff_hold_ctl.sv
// Pause controller: decides when the serial interface is on hold.
// Assumes synchronized inputs. Entry needs the pause pin low and the
// serial clock low; exit needs the pause pin high and the clock low.
// A released select always forces the run phase.
module sff_hold_ctl
    import sff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic held
);
    hold_ph_t ph, ph_nxt;

    // next phase from the pause pin, qualified by the clock low phase
    always_comb begin
        ph_nxt = ph;
        if (!cs_act) begin
            ph_nxt = PH_RUN;
        end else begin
            unique case (ph)
                PH_RUN:  if (!hold_n_s && !sck_s) ph_nxt = PH_HELD;
                PH_HELD: if (hold_n_s && !sck_s)  ph_nxt = PH_RUN;
                default: ph_nxt = PH_RUN;
            endcase
        end
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_RUN;
        else        ph <= ph_nxt;
    end

    assign held = (ph == PH_HELD);
endmodule

// File: rtl/sff_rx_shift.sv
// Receive shifter: collects input bits MSB first on qualified rising
// edges, publishes each byte with a one-cycle strobe and a saturating
// index within the frame.
// Assumes: rise_q already excludes hold and an idle select; consecutive
// strobes are separated by many cycles (serial clock <= clk/4).
module sff_rx_shift #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rise_q,
    input  logic              sdi_s,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [IDX_W-1:0]  rx_index,
    output logic              byte_start
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] IDX_MAX  = {IDX_W{1'b1}};

    logic [BYTE_W-2:0] sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  byte_cnt;

    // bit accumulation and byte completion; a released select clears all
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            rx_byte  <= '0;
            rx_index <= '0;
            rx_valid <= 1'b0;
        end else if (!cs_act) begin
            sh       <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise_q) begin
                sh <= {sh[BYTE_W-3:0], sdi_s};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt  <= '0;
                    rx_byte  <= {sh, sdi_s};
                    rx_index <= byte_cnt;
                    rx_valid <= 1'b1;
                    if (byte_cnt != IDX_MAX) byte_cnt <= byte_cnt + 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign byte_start = (bit_cnt == '0);
endmodule

// File: rtl/sff_tx_shift.sv
// Transmit shifter: loads the response byte on the first falling edge of a
// byte slot and moves one bit per later falling edge, MSB first.
// Assumes: fall_q already excludes hold and an idle select; the output is
// released while on hold without losing the shifter contents.
module sff_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              fall_q,
    input  logic              byte_start,
    input  logic              held,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_en,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [BYTE_W-1:0] tx_sh;
    logic              oe_q;

    // load at slot start, shift otherwise; a released select clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            oe_q  <= 1'b0;
        end else if (!cs_act) begin
            tx_sh <= '0;
            oe_q  <= 1'b0;
        end else if (fall_q) begin
            if (byte_start) begin
                tx_sh <= tx_data;
                oe_q  <= tx_en;
            end else begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // output drive is gated by hold so the pad floats while paused
    always_comb begin
        sdo_oe = oe_q && !held;
        sdo    = sdo_oe ? tx_sh[BYTE_W-1] : 1'b0;
    end
endmodule

// File: rtl/spi_flash_front.sv
// SPI flash slave front end: oversamples the select, clock, data and
// pause pins, rebuilds bit edges, applies the hold rules and hands bytes
// to the command logic; shifts response bytes out with an enable.
// Assumes: serial clock at most one quarter of clk; the pins are
// asynchronous to clk; Mode 0 and Mode 3 use the same capture and launch
// edges.
module spi_flash_front
    import sff_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_pin,
    input  logic                  sck_pin,
    input  logic                  sdi_pin,
    input  logic                  hold_n_pin,
    input  logic [SFF_BYTE_W-1:0] tx_data,
    input  logic                  tx_en,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic [SFF_BYTE_W-1:0] rx_byte,
    output logic                  rx_valid,
    output logic [IDX_W-1:0]      rx_index
);
    localparam logic [PIN_NUM-1:0] PIN_IDLE =
        PIN_NUM'((1 << PIN_CS) | (1 << PIN_HOLD));

    logic [PIN_NUM-1:0] pins_raw, pins_s;
    logic cs_act, sck_s, sdi_s, hold_n_s;
    logic sck_prev, sck_rise, sck_fall;
    logic held, rise_q, fall_q, byte_start;

    // pack the pins in package order for the synchronizer
    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_CS]   = cs_n_pin;
        pins_raw[PIN_SCK]  = sck_pin;
        pins_raw[PIN_SDI]  = sdi_pin;
        pins_raw[PIN_HOLD] = hold_n_pin;
    end

    sff_sync #(
        .W       (PIN_NUM),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    assign cs_act   = !pins_s[PIN_CS];
    assign sck_s    = pins_s[PIN_SCK];
    assign sdi_s    = pins_s[PIN_SDI];
    assign hold_n_s = pins_s[PIN_HOLD];

    // previous clock level for edge detection, tracked even while held
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign sck_rise = sck_s && !sck_prev;
    assign sck_fall = !sck_s && sck_prev;
    assign rise_q   = sck_rise && cs_act && !held;
    assign fall_q   = sck_fall && cs_act && !held;

    sff_hold_ctl u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sck_s    (sck_s),
        .hold_n_s (hold_n_s),
        .held     (held)
    );

    sff_rx_shift #(
        .BYTE_W (SFF_BYTE_W),
        .IDX_W  (IDX_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .rise_q     (rise_q),
        .sdi_s      (sdi_s),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_index   (rx_index),
        .byte_start (byte_start)
    );

    sff_tx_shift #(
        .BYTE_W (SFF_BYTE_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .fall_q     (fall_q),
        .byte_start (byte_start),
        .held       (held),
        .tx_data    (tx_data),
        .tx_en      (tx_en),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );
endmodule

// File: rtl/sff_chk.sv
// Protocol checker for the SPI flash slave front end, bound to the top.
// Assumes the synchronized pin views and hold phase of the top level.
module sff_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic             held,
    input logic             sck_s,
    input logic             hold_n_s,
    input logic             rx_valid,
    input logic [IDX_W-1:0] rx_index,
    input logic             sdo_oe
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic [IDX_W-1:0] exp_idx;

    // independent model of the expected byte position in the frame
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) exp_idx <= '0;
        else if (rx_valid && exp_idx != IDX_MAX) exp_idx <= exp_idx + 1'b1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!rx_valid && !sdo_oe));

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_index_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_index == exp_idx));

    p_hold_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(!sck_s && !hold_n_s && cs_act));

    p_hold_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(held) && cs_act) |-> $past(!sck_s && hold_n_s));

    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> !rx_valid);

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_act) |=> !held);
endmodule

bind spi_flash_front sff_chk #(.IDX_W(IDX_W)) u_sff_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .held     (held),
    .sck_s    (sck_s),
    .hold_n_s (hold_n_s),
    .rx_valid (rx_valid),
    .rx_index (rx_index),
    .sdo_oe   (sdo_oe)
);

// File: tb/tb_spi_flash_front.sv
// Scoreboard bench: the byte driver queues expected bytes and indices, a
// monitor pops them as the design strobes; serial output bits and the
// output enable are checked at each master sampling point.
module tb_spi_flash_front;
    localparam int IDX_W   = 3;
    localparam int IDX_MAX = (1 << IDX_W) - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_en = 1'b0;
    logic       sdo, sdo_oe, rx_valid;
    logic [7:0] rx_byte;
    logic [IDX_W-1:0] rx_index;

    spi_flash_front #(.IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck),
        .sdi_pin(si), .hold_n_pin(hold_n), .tx_data(tx_data),
        .tx_en(tx_en), .sdo(sdo), .sdo_oe(sdo_oe), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_index(rx_index)
    );

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } item_t;

    item_t exp_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    int    exp_idx = 0;
    logic  mode3   = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (4) @(negedge clk);
    endtask

    // monitor: compare every strobe with the head of the scoreboard
    always @(negedge clk) begin
        item_t e;
        if (rst_n && rx_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R2 unexpected strobe: actual %0h expected none", rx_byte);
            end else begin
                e = exp_q.pop_front();
                check("R2", "rx_byte", rx_byte, e.data);
                check("R3", "rx_index", rx_index, e.idx);
            end
        end
    end

    task automatic frame_begin(input logic m3);
        mode3 = m3;
        cs_n  = 1'b1;
        sck   = m3;
        wait_half();
        cs_n    = 1'b0;
        exp_idx = 0;
        wait_half();
    endtask

    task automatic frame_end();
        tx_en = 1'b0;
        if (sck && !mode3) begin
            sck = 1'b0;
            wait_half();
        end
        cs_n = 1'b1;
        wait_half();
        wait_half();
    endtask

    // kind: 0 plain, 1 hold in clock-low phase, 2 deferred hold,
    // 3 hold then select release, 4 select release without hold
    task automatic xfer(input logic [7:0] b, input logic [7:0] resp,
                        input logic oe_exp, input int cut_at, input int kind);
        item_t it;
        if (kind < 3) begin
            it.idx  = IDX_W'(exp_idx);
            it.data = b;
            exp_q.push_back(it);
            if (exp_idx < IDX_MAX) exp_idx++;
        end
        tx_data = resp;
        tx_en   = oe_exp;
        for (int i = 7; i >= 0; i--) begin
            if (sck) begin
                sck = 1'b0;
                wait_half();
            end
            if (i == cut_at && (kind == 1 || kind == 3)) begin
                check("R6", "sdo_oe before hold", sdo_oe, oe_exp);
                hold_n = 1'b0;
                wait_half();
                check("R6", "sdo_oe on hold", sdo_oe, 0);
                si  = ~b[i];          // R7: edges while held are ignored
                sck = 1'b1;
                wait_half();
                sck = 1'b0;
                wait_half();
                if (kind == 3) begin
                    cs_n = 1'b1;
                    wait_half();
                    check("R8", "sdo_oe after release on hold", sdo_oe, 0);
                    hold_n = 1'b1;
                    wait_half();
                    tx_en = 1'b0;
                    return;
                end
                hold_n = 1'b1;
                wait_half();
                check("R10", "sdo_oe after hold exit", sdo_oe, oe_exp);
            end
            si = b[i];
            wait_half();
            check("R5", "sdo_oe", sdo_oe, oe_exp);
            if (oe_exp) check("R5", "sdo bit", sdo, resp[i]);
            sck = 1'b1;
            wait_half();
            if (i == cut_at && kind == 2) begin
                hold_n = 1'b0;        // clock high: entry must wait
                wait_half();
                check("R6", "sdo_oe deferred entry", sdo_oe, oe_exp);
                sck = 1'b0;
                wait_half();
                check("R6", "sdo_oe after deferred entry", sdo_oe, 0);
                si  = ~si;
                sck = 1'b1;
                wait_half();
                hold_n = 1'b1;        // clock high: exit must wait
                wait_half();
                check("R7", "sdo_oe deferred exit", sdo_oe, 0);
            end
            if (i == cut_at && kind == 4) begin
                cs_n = 1'b1;
                wait_half();
                wait_half();
                check("R9", "sdo_oe after mid-byte release", sdo_oe, 0);
                tx_en = 1'b0;
                return;
            end
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "sdo_oe after reset", sdo_oe, 0);
        check("R1", "rx_valid after reset", rx_valid, 0);

        // R1: clock and data activity with select high
        for (int k = 0; k < 16; k++) begin
            si  = k[0];
            sck = 1'b1;
            wait_half();
            sck = 1'b0;
            wait_half();
        end
        check("R1", "sdo_oe while deselected", sdo_oe, 0);

        // R2 R5: Mode 0 read-style frame with two response bytes
        frame_begin(1'b0);
        xfer(8'h03, 8'h00, 1'b0, -1, 0);
        xfer(8'h12, 8'h00, 1'b0, -1, 0);
        xfer(8'hA5, 8'hA5, 1'b1, -1, 0);
        xfer(8'h00, 8'h3C, 1'b1, -1, 0);
        frame_end();

        // R4: same kind of frame with the clock idling high
        frame_begin(1'b1);
        xfer(8'h9F, 8'h00, 1'b0, -1, 0);
        xfer(8'h5A, 8'hC3, 1'b1, -1, 0);
        xfer(8'h81, 8'h5A, 1'b1, -1, 0);
        frame_end();
        check("R4", "bytes pending after Mode 3 frame", exp_q.size(), 0);

        // R3: long frame, index saturates at IDX_MAX
        frame_begin(1'b0);
        for (int k = 0; k < 10; k++) xfer(8'(8'h20 + k), 8'h00, 1'b0, -1, 0);
        frame_end();
        check("R3", "bytes pending after long frame", exp_q.size(), 0);

        // R6 R7 R10: prompt and deferred hold in the middle of bytes
        frame_begin(1'b0);
        xfer(8'h0B, 8'h00, 1'b0, -1, 0);
        xfer(8'hC6, 8'h96, 1'b1, 4, 1);
        xfer(8'h39, 8'hE1, 1'b1, 2, 2);
        frame_end();
        frame_begin(1'b1);
        xfer(8'h6D, 8'h00, 1'b0, -1, 0);
        xfer(8'hB2, 8'h4B, 1'b1, 5, 2);
        frame_end();
        check("R7", "bytes pending after hold frames", exp_q.size(), 0);

        // R8: release select while on hold, then a clean frame
        frame_begin(1'b0);
        xfer(8'h02, 8'h00, 1'b0, -1, 0);
        xfer(8'hFF, 8'h77, 1'b1, 5, 3);
        frame_begin(1'b1);
        xfer(8'h44, 8'h00, 1'b0, -1, 0);   // R8: index back to 0
        xfer(8'h1E, 8'h00, 1'b0, -1, 0);
        frame_end();
        check("R8", "bytes pending after abort", exp_q.size(), 0);

        // R9: release select mid-byte without hold, then a clean frame
        frame_begin(1'b0);
        xfer(8'h05, 8'h00, 1'b0, -1, 0);
        xfer(8'hF0, 8'hAA, 1'b1, 3, 4);
        frame_begin(1'b0);
        xfer(8'h7E, 8'h00, 1'b0, -1, 0);   // R9: counters restarted
        frame_end();
        check("R9", "bytes pending after mid-byte release", exp_q.size(), 0);

        summary();
        $finish;
    end
endmodule